// File: doc/BRIEF.md
# Standby Wake Controller

This block controls a deep power-down state in which the chip-wide clock is switched off. Software arms a standby-enable register and then raises a sleep request. If the committed enable value is 1 at that moment, both clock enables drop and the block waits for a wake event. Before entry, software stops the watchdog-style counter, clears it and chooses its prescaler.

A wake event is a chosen edge on the non-maskable interrupt line, or a chosen edge on one of eight interrupt request lines whose priority is above the CPU mask level. It turns on the clock to the settling counter only. The main clock comes back when that counter overflows, and the block then sends a one-cycle wake indication that names its source. A manual or power-on reset skips the settling wait and returns the block to the running state at once.

Top module: `standby_wake_ctrl`

## Requirements
- R1: A sleep request moves the block into standby only if the committed standby-enable value is 1 in the same cycle. Otherwise the request is ignored, the chip clock enable stays 1, and edges on the wake lines while running produce no wake indication.
- R2: A write to the standby-enable register commits COMMIT_LAT (default 2) cycles after the write is sampled. The read-back port shows only the committed value, and a sleep request made before the commit uses the old value.
- R3: In standby, chipClkEn and settleClkEn are both 0. settleClkEn is 1 only while settling, and chipClkEn is 1 only in the running state.
- R4: nmiEdgeSel = 0 selects a falling edge of nmiPin and 1 selects a rising edge. The opposite edge does not wake the block.
- R5: Request line i has the sense code irqSense[2i+1:2i]: 00 never wakes, 01 wakes on a falling edge, 10 on a rising edge, 11 on either edge.
- R6: Request line i wakes the block only if its priority irqPrio[4i+3:4i] is strictly greater than cpuMask. Otherwise the block stays in standby.
- R7: Settling begins on the cycle after the wake edge is sampled and lasts exactly 256 * 2^(cks+1) cycles when the count starts from 0. The 8-bit counter advances once every 2^(cks+1) cycles and overflows on the carry out of 0xFF.
- R8: At overflow, chipClkEn returns to 1 and wakeValid is 1 for exactly one cycle. In that cycle wakeNmi = 1 for an NMI wake, or wakeNmi = 0 with wakeIrqId set to the line number for a request-line wake.
- R9: When several events occur in the same cycle, the NMI wins over the request lines and the lowest line index wins among the request lines. Only the first wake event is latched, and edges that arrive during settling do not change the reported source.
- R10: A manual reset (manRstN low, sampled) or a power-on reset (porRstN low, asynchronous) during standby or settling returns the block to running with the clocks enabled, the counter at 0 and no wake indication. A power-on reset also clears the standby-enable register.
- R11: In the running state, cntClr sets the counter and the prescaler to 0. With wdtRun = 1 the counter advances at the prescaled rate, and with wdtRun = 0 it holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running oscillator clock |
| porRstN | input | 1 | Asynchronous power-on reset, active low |
| manRstN | input | 1 | Synchronous manual reset, active low |
| stbyWrEn | input | 1 | Write strobe for the standby-enable register |
| stbyWrData | input | 1 | Value written to the standby-enable register |
| stbyRdData | output | 1 | Committed standby-enable value |
| sleepReq | input | 1 | Sleep request pulse from the CPU |
| wdtRun | input | 1 | Counter run bit, used in the running state |
| cntClr | input | 1 | Clears the counter and the prescaler |
| cks | input | 3 | Prescaler select, divide by 2^(cks+1) |
| cntVal | output | 8 | Current counter value |
| nmiPin | input | 1 | Non-maskable interrupt line |
| nmiEdgeSel | input | 1 | NMI edge select: 0 falling, 1 rising |
| irqPins | input | 8 | Interrupt request lines |
| irqSense | input | 16 | Two-bit sense code for each line |
| irqPrio | input | 32 | Four-bit priority for each line |
| cpuMask | input | 4 | CPU interrupt mask level |
| chipClkEn | output | 1 | Chip-wide clock enable |
| settleClkEn | output | 1 | Clock enable for the settling counter |
| wakeValid | output | 1 | One-cycle wake indication |
| wakeNmi | output | 1 | Wake source is the NMI |
| wakeIrqId | output | 3 | Request line that caused the wake |

## Verification
The wake path runs under seeded random trials. Each trial picks the NMI or one request line, then draws an edge direction, an edge select or sense code, a priority against a mask, and a prescaler setting. The bench predicts whether the block wakes and, if it does, how many settling cycles must pass. Trials where the edge matches the selection are told apart from those where it does not, those with priority above the mask from those with priority at or below it, and sense code 00 from the edge codes. Directed cases cover the rest:
- the commit delay, with a sleep request made just before the write lands;
- events on two sources in the same cycle, and edges that arrive during settling;
- manual and power-on reset in the middle of standby or settling;
- the counter's clear, run and hold behaviour.

// File: rtl/stby_pkg.sv
package stby_pkg;

  typedef enum logic [1:0] {
    ST_RUN     = 2'd0,
    ST_STANDBY = 2'd1,
    ST_SETTLE  = 2'd2
  } stbyState_e;

  // Strobes from the control FSM to the counter datapath
  typedef struct packed {
    logic clrAll;   // clear prescaler and counter
    logic clrPsc;   // restart the prescaler at wake entry
    logic countEn;  // advance prescaler / counter
  } dpStrobe_t;

endpackage

// File: rtl/stby_en_reg.sv
module stby_en_reg #(
  parameter int COMMIT_LAT = 2
) (
  input  logic clk,
  input  logic porRstN,
  input  logic wrEn,
  input  logic wrData,
  output logic committed
);

  generate
    if (COMMIT_LAT <= 1) begin : g_direct
      always_ff @(posedge clk or negedge porRstN) begin
        if (!porRstN) committed <= 1'b0;
        else if (wrEn) committed <= wrData;
      end
    end else begin : g_pipe
      localparam int STAGES = COMMIT_LAT - 1;
      logic [STAGES-1:0] pendVld;
      logic [STAGES-1:0] pendDat;

      always_ff @(posedge clk or negedge porRstN) begin
        if (!porRstN) begin
          pendVld   <= '0;
          pendDat   <= '0;
          committed <= 1'b0;
        end else begin
          pendVld[0] <= wrEn;
          pendDat[0] <= wrData;
          for (int s = 1; s < STAGES; s++) begin
            pendVld[s] <= pendVld[s-1];
            pendDat[s] <= pendDat[s-1];
          end
          if (pendVld[STAGES-1]) committed <= pendDat[STAGES-1];
        end
      end

      // R2: the committed value never changes in the cycle right after a
      // write is sampled, because the write is still in the pipeline
      AST_COMMIT_NOT_EARLY: assert property (@(posedge clk) disable iff (!porRstN)
        (wrEn && !pendVld[STAGES-1]) |=> $stable(committed)); // R2
    end
  endgenerate

endmodule

// File: rtl/stby_wake_det.sv
module stby_wake_det #(
  parameter int NUM_IRQ = 8,
  parameter int PRIO_W  = 4,
  localparam int IDW    = $clog2(NUM_IRQ)
) (
  input  logic                      clk,
  input  logic                      porRstN,
  input  logic                      nmiPin,
  input  logic                      nmiEdgeSel,
  input  logic [NUM_IRQ-1:0]        irqPins,
  input  logic [2*NUM_IRQ-1:0]      irqSense,
  input  logic [PRIO_W*NUM_IRQ-1:0] irqPrio,
  input  logic [PRIO_W-1:0]         cpuMask,
  output logic                      nmiHit,
  output logic                      irqHit,
  output logic [IDW-1:0]            irqId
);

  logic               nmiPrev;
  logic [NUM_IRQ-1:0] irqPrev;
  logic [NUM_IRQ-1:0] irqQual;

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) begin
      nmiPrev <= 1'b0;
      irqPrev <= '0;
    end else begin
      nmiPrev <= nmiPin;
      irqPrev <= irqPins;
    end
  end

  assign nmiHit = nmiEdgeSel ? (nmiPin & ~nmiPrev) : (~nmiPin & nmiPrev);

  genvar gi;
  generate
    for (gi = 0; gi < NUM_IRQ; gi++) begin : g_line
      logic       rise;
      logic       fall;
      logic       edgeOk;
      logic [1:0] sense;
      assign rise  = irqPins[gi] & ~irqPrev[gi];
      assign fall  = ~irqPins[gi] & irqPrev[gi];
      assign sense = irqSense[2*gi +: 2];
      always_comb begin
        unique case (sense)
          2'b01:   edgeOk = fall;
          2'b10:   edgeOk = rise;
          2'b11:   edgeOk = rise | fall;
          default: edgeOk = 1'b0;
        endcase
      end
      assign irqQual[gi] = edgeOk && (irqPrio[PRIO_W*gi +: PRIO_W] > cpuMask);
    end
  endgenerate

  // Lowest index wins
  always_comb begin
    irqHit = 1'b0;
    irqId  = '0;
    for (int i = NUM_IRQ - 1; i >= 0; i--) begin
      if (irqQual[i]) begin
        irqHit = 1'b1;
        irqId  = IDW'(i);
      end
    end
  end

  // R6: a reported line always has priority above the mask
  AST_IRQ_ABOVE_MASK: assert property (@(posedge clk) disable iff (!porRstN)
    irqHit |-> (irqPrio[PRIO_W*irqId +: PRIO_W] > cpuMask)); // R6

endmodule

// File: rtl/stby_settle_dp.sv
module stby_settle_dp import stby_pkg::*; #(
  parameter int CNT_W  = 8,
  parameter int CKS_W  = 3,
  localparam int PSC_W = 1 << CKS_W
) (
  input  logic             clk,
  input  logic             porRstN,
  input  dpStrobe_t        strobe,
  input  logic [CKS_W-1:0] cks,
  output logic [CNT_W-1:0] cntVal,
  output logic             ovf
);

  logic [PSC_W-1:0] pscQ;
  logic [PSC_W-1:0] tickMask;
  logic             tick;

  always_comb begin
    for (int i = 0; i < PSC_W; i++) tickMask[i] = (i <= int'(cks));
  end

  assign tick = strobe.countEn && ((pscQ & tickMask) == tickMask);
  assign ovf  = tick && (cntVal == {CNT_W{1'b1}});

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) begin
      pscQ   <= '0;
      cntVal <= '0;
    end else if (strobe.clrAll) begin
      pscQ   <= '0;
      cntVal <= '0;
    end else begin
      if (strobe.clrPsc)       pscQ <= '0;
      else if (strobe.countEn) pscQ <= pscQ + 1'b1;
      if (tick) cntVal <= cntVal + 1'b1;
    end
  end

  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!porRstN)
    (!strobe.countEn && !strobe.clrAll) |=> $stable(cntVal)); // R11
  AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!porRstN)
    strobe.clrAll |=> (cntVal == '0)); // R10

endmodule

// File: rtl/stby_ctrl.sv
module stby_ctrl import stby_pkg::*; #(
  parameter int IDW = 3
) (
  input  logic           clk,
  input  logic           porRstN,
  input  logic           manRstN,
  input  logic           sleepReq,
  input  logic           stbyEn,
  input  logic           wdtRun,
  input  logic           cntClr,
  input  logic           nmiHit,
  input  logic           irqHit,
  input  logic [IDW-1:0] irqId,
  input  logic           ovf,
  output dpStrobe_t      strobe,
  output logic           chipClkEn,
  output logic           settleClkEn,
  output logic           wakeValid,
  output logic           wakeNmi,
  output logic [IDW-1:0] wakeIrqId
);

  stbyState_e     stateQ;
  stbyState_e     stateD;
  logic           wakeHit;
  logic           srcNmiQ;
  logic [IDW-1:0] srcIdQ;

  assign wakeHit = nmiHit | irqHit;

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      ST_RUN:     if (sleepReq && stbyEn) stateD = ST_STANDBY;
      ST_STANDBY: if (wakeHit)            stateD = ST_SETTLE;
      ST_SETTLE:  if (ovf)                stateD = ST_RUN;
      default:                            stateD = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) begin
      stateQ    <= ST_RUN;
      wakeValid <= 1'b0;
      srcNmiQ   <= 1'b0;
      srcIdQ    <= '0;
    end else if (!manRstN) begin
      stateQ    <= ST_RUN;
      wakeValid <= 1'b0;
      srcNmiQ   <= 1'b0;
      srcIdQ    <= '0;
    end else begin
      stateQ    <= stateD;
      wakeValid <= (stateQ == ST_SETTLE) && ovf;
      if (stateQ == ST_STANDBY && wakeHit) begin
        srcNmiQ <= nmiHit;
        srcIdQ  <= nmiHit ? '0 : irqId;
      end
    end
  end

  assign strobe.countEn = (stateQ == ST_SETTLE) || (stateQ == ST_RUN && wdtRun);
  assign strobe.clrPsc  = (stateQ == ST_STANDBY) && wakeHit;
  assign strobe.clrAll  = !manRstN || (stateQ == ST_RUN && cntClr);

  assign chipClkEn   = (stateQ == ST_RUN);
  assign settleClkEn = (stateQ == ST_SETTLE);
  assign wakeNmi     = srcNmiQ;
  assign wakeIrqId   = srcIdQ;

  AST_NO_ENTRY_WITHOUT_ENABLE: assert property (@(posedge clk) disable iff (!porRstN)
    (stateQ == ST_RUN && !stbyEn) |=> (stateQ == ST_RUN)); // R1
  AST_STANDBY_NEEDS_EVENT: assert property (@(posedge clk) disable iff (!porRstN)
    (stateQ == ST_STANDBY && !wakeHit && manRstN) |=> (stateQ == ST_STANDBY)); // R6
  AST_SETTLE_UNTIL_OVF: assert property (@(posedge clk) disable iff (!porRstN)
    (stateQ == ST_SETTLE && !ovf && manRstN) |=> (stateQ == ST_SETTLE)); // R7
  AST_WAKE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!porRstN)
    wakeValid |=> !wakeValid); // R8
  AST_SRC_LATCHED: assert property (@(posedge clk) disable iff (!porRstN)
    (stateQ == ST_SETTLE && manRstN) |=> $stable(srcNmiQ) && $stable(srcIdQ)); // R9
  AST_MANRST_RUN: assert property (@(posedge clk) disable iff (!porRstN)
    !manRstN |=> (stateQ == ST_RUN) && !wakeValid); // R10

endmodule

// File: rtl/standby_wake_ctrl.sv
module standby_wake_ctrl import stby_pkg::*; #(
  parameter int NUM_IRQ    = 8,
  parameter int PRIO_W     = 4,
  parameter int CNT_W      = 8,
  parameter int CKS_W      = 3,
  parameter int COMMIT_LAT = 2,
  localparam int IDW       = $clog2(NUM_IRQ)
) (
  input  logic                      clk,
  input  logic                      porRstN,
  input  logic                      manRstN,
  input  logic                      stbyWrEn,
  input  logic                      stbyWrData,
  output logic                      stbyRdData,
  input  logic                      sleepReq,
  input  logic                      wdtRun,
  input  logic                      cntClr,
  input  logic [CKS_W-1:0]          cks,
  output logic [CNT_W-1:0]          cntVal,
  input  logic                      nmiPin,
  input  logic                      nmiEdgeSel,
  input  logic [NUM_IRQ-1:0]        irqPins,
  input  logic [2*NUM_IRQ-1:0]      irqSense,
  input  logic [PRIO_W*NUM_IRQ-1:0] irqPrio,
  input  logic [PRIO_W-1:0]         cpuMask,
  output logic                      chipClkEn,
  output logic                      settleClkEn,
  output logic                      wakeValid,
  output logic                      wakeNmi,
  output logic [IDW-1:0]            wakeIrqId
);

  dpStrobe_t      strobe;
  logic           stbyEn;
  logic           nmiHit;
  logic           irqHit;
  logic [IDW-1:0] irqId;
  logic           ovf;

  assign stbyRdData = stbyEn;

  stby_en_reg #(.COMMIT_LAT(COMMIT_LAT)) uEnReg (
    .clk(clk), .porRstN(porRstN), .wrEn(stbyWrEn), .wrData(stbyWrData),
    .committed(stbyEn)
  );

  stby_wake_det #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W)) uWakeDet (
    .clk(clk), .porRstN(porRstN), .nmiPin(nmiPin), .nmiEdgeSel(nmiEdgeSel),
    .irqPins(irqPins), .irqSense(irqSense), .irqPrio(irqPrio), .cpuMask(cpuMask),
    .nmiHit(nmiHit), .irqHit(irqHit), .irqId(irqId)
  );

  stby_settle_dp #(.CNT_W(CNT_W), .CKS_W(CKS_W)) uDp (
    .clk(clk), .porRstN(porRstN), .strobe(strobe), .cks(cks),
    .cntVal(cntVal), .ovf(ovf)
  );

  stby_ctrl #(.IDW(IDW)) uCtrl (
    .clk(clk), .porRstN(porRstN), .manRstN(manRstN), .sleepReq(sleepReq),
    .stbyEn(stbyEn), .wdtRun(wdtRun), .cntClr(cntClr), .nmiHit(nmiHit),
    .irqHit(irqHit), .irqId(irqId), .ovf(ovf), .strobe(strobe),
    .chipClkEn(chipClkEn), .settleClkEn(settleClkEn), .wakeValid(wakeValid),
    .wakeNmi(wakeNmi), .wakeIrqId(wakeIrqId)
  );

endmodule

// File: tb/tb_standby_wake_ctrl.sv
module tb_standby_wake_ctrl;

  localparam time CLK_P = 20ns;

  logic        clk = 1'b0;
  logic        porRstN = 1'b0;
  logic        manRstN = 1'b1;
  logic        stbyWrEn = 1'b0;
  logic        stbyWrData = 1'b0;
  logic        stbyRdData;
  logic        sleepReq = 1'b0;
  logic        wdtRun = 1'b0;
  logic        cntClr = 1'b0;
  logic [2:0]  cks = 3'd0;
  logic [7:0]  cntVal;
  logic        nmiPin = 1'b0;
  logic        nmiEdgeSel = 1'b0;
  logic [7:0]  irqPins = '0;
  logic [15:0] irqSense = '0;
  logic [31:0] irqPrio = '0;
  logic [3:0]  cpuMask = '0;
  logic        chipClkEn;
  logic        settleClkEn;
  logic        wakeValid;
  logic        wakeNmi;
  logic [2:0]  wakeIrqId;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  standby_wake_ctrl dut (
    .clk(clk), .porRstN(porRstN), .manRstN(manRstN), .stbyWrEn(stbyWrEn),
    .stbyWrData(stbyWrData), .stbyRdData(stbyRdData), .sleepReq(sleepReq),
    .wdtRun(wdtRun), .cntClr(cntClr), .cks(cks), .cntVal(cntVal),
    .nmiPin(nmiPin), .nmiEdgeSel(nmiEdgeSel), .irqPins(irqPins),
    .irqSense(irqSense), .irqPrio(irqPrio), .cpuMask(cpuMask),
    .chipClkEn(chipClkEn), .settleClkEn(settleClkEn), .wakeValid(wakeValid),
    .wakeNmi(wakeNmi), .wakeIrqId(wakeIrqId)
  );

  function automatic int settleLen(input logic [2:0] c);
    return 256 << (int'(c) + 1);
  endfunction

  function automatic bit irqWakes(input logic [1:0] sense, input bit rising,
                                  input logic [3:0] prio, input logic [3:0] mask);
    bit edgeOk;
    case (sense)
      2'b01:   edgeOk = !rising;
      2'b10:   edgeOk = rising;
      2'b11:   edgeOk = 1'b1;
      default: edgeOk = 1'b0;
    endcase
    return edgeOk && (prio > mask);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic writeStby(input logic v);
    @(negedge clk); stbyWrEn = 1'b1; stbyWrData = v;
    @(negedge clk); stbyWrEn = 1'b0;
    @(negedge clk);
  endtask

  task automatic enterStandby();
    @(negedge clk); cntClr = 1'b1;
    @(negedge clk); cntClr = 1'b0; sleepReq = 1'b1;
    @(negedge clk); sleepReq = 1'b0;
    check(!chipClkEn && !settleClkEn, "R3 standby clocks off",
          {chipClkEn, settleClkEn}, 0);
  endtask

  // Caller has driven the wake edge at the current negedge
  task automatic measureWake(input bit expNmi, input logic [2:0] expId, input int len,
                             input string tag);
    int n = 0;
    int guard = 0;
    while (!chipClkEn && guard < len + 50) begin
      @(negedge clk);
      if (settleClkEn) n++;
      guard++;
    end
    check(n == len, {"R7 settle length ", tag}, n, len);
    check(wakeValid == 1'b1, {"R8 wake pulse ", tag}, wakeValid, 1);
    check(wakeNmi == expNmi, {"R9 wake source nmi ", tag}, wakeNmi, expNmi);
    if (!expNmi) check(wakeIrqId == expId, {"R8 wake line ", tag}, wakeIrqId, expId);
    @(negedge clk);
    check(!wakeValid && chipClkEn, {"R8 pulse one cycle ", tag}, wakeValid, 0);
  endtask

  task automatic manualReset(input string tag);
    @(negedge clk); manRstN = 1'b0;
    @(negedge clk);
    check(chipClkEn && !settleClkEn && !wakeValid && cntVal == 8'd0,
          {"R10 manual reset ", tag}, {chipClkEn, settleClkEn, wakeValid}, 3'b100);
    manRstN = 1'b1;
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    #(CLK_P * 3);
    @(negedge clk); porRstN = 1'b1;
    @(negedge clk);
    check(chipClkEn && !settleClkEn && !wakeValid && !stbyRdData,
          "R10 reset state", {chipClkEn, settleClkEn, wakeValid, stbyRdData}, 4'b1000);

    // R11: counter clear, run, hold
    @(negedge clk); cks = 3'd0; cntClr = 1'b1;
    @(negedge clk); cntClr = 1'b0; wdtRun = 1'b1;
    repeat (9) @(negedge clk);
    @(negedge clk); wdtRun = 1'b0;
    check(cntVal == 8'd5, "R11 counter runs at prescaled rate", cntVal, 5);
    repeat (5) @(negedge clk);
    check(cntVal == 8'd5, "R11 counter holds when stopped", cntVal, 5);
    @(negedge clk); cntClr = 1'b1;
    @(negedge clk); cntClr = 1'b0;
    check(cntVal == 8'd0, "R11 counter cleared", cntVal, 0);

    // R1: sleep with enable 0 is ignored, run-mode edges give no wake
    @(negedge clk); sleepReq = 1'b1; nmiEdgeSel = 1'b1; nmiPin = 1'b1;
    @(negedge clk); sleepReq = 1'b0;
    check(chipClkEn && !wakeValid, "R1 sleep ignored when disabled", chipClkEn, 1);
    repeat (3) @(negedge clk);
    check(chipClkEn && !wakeValid, "R1 edge while running", wakeValid, 0);
    nmiPin = 1'b0;

    // R2: commit delay and sleep before commit
    @(negedge clk); stbyWrEn = 1'b1; stbyWrData = 1'b1;
    @(negedge clk); stbyWrEn = 1'b0; sleepReq = 1'b1;
    check(stbyRdData == 1'b0, "R2 read-back before commit", stbyRdData, 0);
    @(negedge clk); sleepReq = 1'b0;
    check(stbyRdData == 1'b1, "R2 read-back after commit", stbyRdData, 1);
    check(chipClkEn == 1'b1, "R2 early sleep uses old value", chipClkEn, 1);

    // R4 directed: falling-edge NMI wake with cks=1
    cks = 3'd1; nmiEdgeSel = 1'b0; nmiPin = 1'b1;
    enterStandby();
    @(negedge clk); nmiPin = 1'b0;
    measureWake(1'b1, 3'd0, settleLen(3'd1), "nmi falling");

    // R9: NMI and IRQ in the same cycle; then two IRQs; then late edges
    cks = 3'd0; nmiEdgeSel = 1'b1; irqSense = 16'hFFFF; irqPrio = 32'hFFFF_FFFF; cpuMask = 4'd3;
    enterStandby();
    @(negedge clk); nmiPin = 1'b1; irqPins = 8'h01;
    measureWake(1'b1, 3'd0, settleLen(3'd0), "nmi over irq");
    nmiPin = 1'b0; irqPins = '0;
    enterStandby();
    @(negedge clk); irqPins = 8'b0010_0100;
    repeat (20) @(negedge clk);
    irqPins = 8'b0010_0101; nmiPin = 1'b1;
    measureWake(1'b0, 3'd2, settleLen(3'd0) - 20, "lowest line, late edges ignored");
    nmiPin = 1'b0; irqPins = '0;

    // R5: sense 00 never wakes
    irqSense = 16'h0000;
    enterStandby();
    @(negedge clk); irqPins = 8'hFF;
    repeat (6) @(negedge clk); irqPins = 8'h00;
    repeat (6) @(negedge clk);
    check(!chipClkEn && !settleClkEn, "R5 sense 00 no wake", settleClkEn, 0);
    manualReset("after sense 00");

    // R10: power-on reset during settling
    irqSense = 16'h0003; irqPrio = 32'h0000_000F; cpuMask = 4'd0;
    enterStandby();
    @(negedge clk); irqPins = 8'h01;
    repeat (10) @(negedge clk);
    porRstN = 1'b0;
    #2;
    check(chipClkEn && !settleClkEn && !wakeValid, "R10 power-on reset in settle",
          chipClkEn, 1);
    @(negedge clk); porRstN = 1'b1; irqPins = '0;
    @(negedge clk);
    check(stbyRdData == 1'b0 && cntVal == 8'd0, "R10 power-on clears enable",
          stbyRdData, 0);
    writeStby(1'b1);
    @(negedge clk);
    check(stbyRdData == 1'b1, "R2 enable rewritten", stbyRdData, 1);

    // Random trials
    for (int t = 0; t < 14; t++) begin
      logic [2:0] rc;
      bit         useNmi;
      bit         rising;
      bit         sel;
      bit         expWake;
      int         line;
      logic [1:0] sense;
      logic [3:0] prio;
      logic [3:0] mask;
      rc     = 3'($urandom % 3);
      useNmi = 1'($urandom % 3 == 0);
      rising = 1'($urandom % 2);
      cks    = rc;
      if (useNmi) begin
        sel        = 1'($urandom % 2);
        nmiEdgeSel = sel;
        nmiPin     = !rising;
        irqSense   = '0;
        expWake    = (sel == rising);
        line       = 0;
      end else begin
        line     = int'($urandom % 8);
        sense    = 2'($urandom % 4);
        prio     = 4'($urandom % 16);
        mask     = 4'($urandom % 16);
        irqSense = '0;
        irqPrio  = '0;
        irqSense[2*line +: 2] = sense;
        irqPrio[4*line +: 4]  = prio;
        cpuMask  = mask;
        irqPins  = '0;
        irqPins[line] = !rising;
        expWake  = irqWakes(sense, rising, prio, mask);
      end
      enterStandby();
      @(negedge clk);
      if (useNmi) nmiPin = rising;
      else irqPins[line] = rising;
      if (expWake) begin
        measureWake(useNmi, 3'(line), settleLen(rc),
                    useNmi ? "random nmi (R4)" : "random irq (R5 R6)");
      end else begin
        repeat (30) @(negedge clk);
        check(!chipClkEn && !settleClkEn && !wakeValid,
              useNmi ? "R4 wrong nmi edge no wake" : "R6 masked or unselected line no wake",
              {chipClkEn, settleClkEn}, 0);
        manualReset("random no-wake");
      end
      nmiPin = 1'b0; irqPins = '0;
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule